// File: doc/BRIEF.md
# Serial Transmit Engine with Pin Loopback and Override

This block turns bytes into asynchronous serial frames on a single transmit pin. A byte is handed over through a valid/ready handshake and is sent as a low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Bit timing comes from an external pulse, `tick_i`, that fires at sixteen times the bit rate. Each bit holds for sixteen of these pulses. A transmit enable gates the engine. Dropping the enable abandons a frame in flight and returns the line to its resting high level.

A pin multiplexer sits between the serializer and the outside world and has three test features. Line loopback copies the incoming receive pin straight onto the transmit pin. System loopback feeds the serializer output into the receive path in place of the receive pin. A software override forces the transmit pin to a chosen level. On the transmit pin, the override wins over line loopback, and line loopback wins over the serializer.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, `tx_pin_o` is 1 and `idle_o` is 1. `ready_o` equals `tx_en_i` while the engine is idle.
- R2: `ready_o` is 1 only when `tx_en_i` is 1 and the engine is idle. A byte is taken at a clock edge where `valid_i` and `ready_o` are both 1. From the next cycle, `idle_o` and `ready_o` are 0.
- R3: The frame is sent in this order: bit position 0 is the start bit (0), positions 1 to 8 are data bits 0 to 7, then the parity bit if enabled, then the stop bit (1). Each bit lasts 16 `tick_i` pulses, and the line changes at the clock edge that samples the 16th pulse.
- R4: With `par_en_i`=1, the parity bit makes the number of ones in data plus parity odd when `par_odd_i`=1 and even when `par_odd_i`=0. With `par_en_i`=0, the stop bit follows data bit 7 directly, giving a 10-bit frame.
- R5: At the edge that samples the 16th pulse of the stop bit, the engine returns to idle. `idle_o` goes to 1 and the serializer output rests at 1.
- R6: While `tx_en_i` is 0, no byte is taken. If `tx_en_i` falls during a frame, the next cycle shows `idle_o`=1 and a serializer output of 1.
- R7: `valid_i` asserted during a frame is ignored. The frame in flight keeps its bit sequence, and no second frame starts before idle.
- R8: With `line_lpbk_i`=1 and `ovrd_en_i`=0, `tx_pin_o` follows `rx_pin_i` combinationally.
- R9: With `sys_lpbk_i`=1, `rx_feed_o` carries the serializer output. With `sys_lpbk_i`=0, it carries `rx_pin_i`.
- R10: With `ovrd_en_i`=1, `tx_pin_o` equals `ovrd_val_i`, whatever the line loopback and serializer states are.
- R11: With `ovrd_en_i`=0 and `line_lpbk_i`=0, `tx_pin_o` equals the serializer output, and it is 1 while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_en_i | input | 1 | Transmit enable |
| par_en_i | input | 1 | Adds a parity bit to the frame |
| par_odd_i | input | 1 | Parity type, 1 = odd, 0 = even |
| sys_lpbk_i | input | 1 | Routes the serializer output to the receive feed |
| line_lpbk_i | input | 1 | Routes the receive pin to the transmit pin |
| ovrd_en_i | input | 1 | Forces the transmit pin to `ovrd_val_i` |
| ovrd_val_i | input | 1 | Forced transmit level |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | `data_i` is valid |
| ready_o | output | 1 | Engine can take a byte |
| rx_pin_i | input | 1 | Raw receive pin |
| tx_pin_o | output | 1 | Transmit pin |
| rx_feed_o | output | 1 | Serial bit delivered to the receiver |
| idle_o | output | 1 | No frame in progress |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse and never comes on two consecutive cycles. They also assume that the parity controls stay fixed while a frame is sent, because the frame image is captured at acceptance. The stimulus changes the parity and loopback controls only while the engine is idle. It raises `tick_i` for one cycle out of every two, and it moves the override and loopback inputs only between checks. All of these inputs are therefore settled before an output is sampled.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic {
    TXS_IDLE = 1'b0,
    TXS_BUSY = 1'b1
  } txs_state_e;

  // Transmit pin priority: override, then line loopback, then serializer.
  function automatic logic pick_tx_pin(input logic ovr_en, input logic ovr_val,
                                       input logic line_on, input logic rx_pin,
                                       input logic ser_bit);
    if (ovr_en) return ovr_val;
    else if (line_on) return rx_pin;
    else return ser_bit;
  endfunction

  // Receiver feed: serializer in system loopback, otherwise the pin.
  function automatic logic pick_rx_feed(input logic sys_on, input logic rx_pin,
                                        input logic ser_bit);
    return sys_on ? ser_bit : rx_pin;
  endfunction

endpackage

// File: rtl/uart_tx_bittimer.sv
module uart_tx_bittimer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bit_end_o = run_i && tick_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R3: without a tick the sub-bit position holds
  a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(cnt_q));

  // R3: a bit boundary restarts the sub-bit count
  a_r3_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |=> (cnt_q == '0));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              bit_end_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              idle_o,
  output logic              ser_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_PAR   = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] LAST_NOPAR = IDX_W'(FRAME_W - 2);

  function automatic logic calc_parity(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Position 0 start, then data LSB first, then parity (or stop), then stop.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                     input logic pen, input logic podd);
    logic pbit;
    pbit = pen ? calc_parity(d, podd) : 1'b1;
    return {1'b1, pbit, d, 1'b0};
  endfunction

  txs_state_e       state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic             ser_q;
  logic             take_byte;
  logic             frame_done;
  logic [IDX_W-1:0] idx_next;

  assign idle_o     = (state_q == TXS_IDLE);
  assign busy_o     = (state_q == TXS_BUSY);
  assign ready_o    = tx_en_i && idle_o;
  assign take_byte  = ready_o && valid_i;
  assign frame_done = busy_o && bit_end_i && (idx_q == last_q);
  assign idx_next   = idx_q + 1'b1;
  assign ser_o      = ser_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXS_IDLE;
      frame_q <= '1;
      idx_q   <= '0;
      last_q  <= LAST_PAR;
      ser_q   <= 1'b1;
    end else if (!tx_en_i) begin
      state_q <= TXS_IDLE;
      ser_q   <= 1'b1;
    end else if (take_byte) begin
      state_q <= TXS_BUSY;
      frame_q <= build_frame(data_i, par_en_i, par_odd_i);
      idx_q   <= '0;
      last_q  <= par_en_i ? LAST_PAR : LAST_NOPAR;
      ser_q   <= 1'b0;
    end else if (frame_done) begin
      state_q <= TXS_IDLE;
      ser_q   <= 1'b1;
    end else if (busy_o && bit_end_i) begin
      idx_q   <= idx_next;
      ser_q   <= frame_q[idx_next];
    end
  end

  // R2: an accepted byte opens a frame with the start bit
  a_r2_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> (!idle_o && !ser_q));

  // R6: a low enable forces the rest state on the next cycle
  a_r6_disable_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> (idle_o && ser_q));

  // R5: idle always goes with a high serializer output
  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> ser_q);

  // R3: a bit holds until its boundary
  a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tx_en_i && !bit_end_i) |=> $stable(ser_q));

  // R5: the end of the last bit returns to idle
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> idle_o);

endmodule

// File: rtl/uart_tx_pinmux.sv
module uart_tx_pinmux
  import uart_tx_pkg::*;
(
  input  logic ser_i,
  input  logic rx_pin_i,
  input  logic sys_lpbk_i,
  input  logic line_lpbk_i,
  input  logic ovrd_en_i,
  input  logic ovrd_val_i,
  output logic tx_pin_o,
  output logic rx_feed_o
);
  always_comb begin
    tx_pin_o  = pick_tx_pin(ovrd_en_i, ovrd_val_i, line_lpbk_i, rx_pin_i, ser_i);
    rx_feed_o = pick_rx_feed(sys_lpbk_i, rx_pin_i, ser_i);
  end

  // R10: the override level reaches the pin
  always_comb begin
    if (ovrd_en_i) a_r10_ovrd_pin: assert (tx_pin_o == ovrd_val_i);
  end

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              tx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              sys_lpbk_i,
  input  logic              line_lpbk_i,
  input  logic              ovrd_en_i,
  input  logic              ovrd_val_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              rx_pin_i,
  output logic              tx_pin_o,
  output logic              rx_feed_o,
  output logic              idle_o
);
  logic busy;
  logic timer_run;
  logic bit_end;
  logic ser_bit;

  assign timer_run = busy && tx_en_i;

  uart_tx_bittimer #(.OSR(OSR)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (timer_run),
    .tick_i    (tick_i),
    .bit_end_o (bit_end)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en_i   (tx_en_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .data_i    (data_i),
    .valid_i   (valid_i),
    .bit_end_i (bit_end),
    .ready_o   (ready_o),
    .busy_o    (busy),
    .idle_o    (idle_o),
    .ser_o     (ser_bit)
  );

  uart_tx_pinmux u_mux (
    .ser_i       (ser_bit),
    .rx_pin_i    (rx_pin_i),
    .sys_lpbk_i  (sys_lpbk_i),
    .line_lpbk_i (line_lpbk_i),
    .ovrd_en_i   (ovrd_en_i),
    .ovrd_val_i  (ovrd_val_i),
    .tx_pin_o    (tx_pin_o),
    .rx_feed_o   (rx_feed_o)
  );

  // R11: with no override or line loopback an idle pin rests high
  a_r11_idle_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovrd_en_i && !line_lpbk_i && idle_o) |-> tx_pin_o);

  // R9: in system loopback the receiver sees what an unforced pin sends
  a_r9_feed_follows_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_lpbk_i && !ovrd_en_i && !line_lpbk_i) |-> (rx_feed_o == tx_pin_o));

  // R2: readiness implies idle
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> idle_o);

endmodule

// File: tb/sim_uart_tx_path.sv
`timescale 1ns/1ps
module sim_uart_tx_path;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, tx_en_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0;
  logic sys_lpbk_i = 1'b0, line_lpbk_i = 1'b0, ovrd_en_i = 1'b0, ovrd_val_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic valid_i = 1'b0, rx_pin_i = 1'b1;
  logic ready_o, tx_pin_o, rx_feed_o, idle_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uart_tx_path u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tx_en_i(tx_en_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .sys_lpbk_i(sys_lpbk_i),
    .line_lpbk_i(line_lpbk_i), .ovrd_en_i(ovrd_en_i), .ovrd_val_i(ovrd_val_i),
    .data_i(data_i), .valid_i(valid_i), .ready_o(ready_o), .rx_pin_i(rx_pin_i),
    .tx_pin_o(tx_pin_o), .rx_feed_o(rx_feed_o), .idle_o(idle_o)
  );

  // {data[7:0], parity enable, parity odd}
  localparam logic [9:0] VECS [6] = '{
    {8'hA5, 1'b1, 1'b0}, {8'h3C, 1'b1, 1'b1}, {8'h00, 1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b0}, {8'h01, 1'b1, 1'b0}, {8'h80, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Ends one time unit after the clock edge that samples a tick.
  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b0;
      @(posedge clk); #1;
      tick_i = 1'b1;
      @(posedge clk); #1;
      tick_i = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic pen, input logic podd,
                      input logic hold_valid, input string req);
    logic [10:0] bits;
    int len;
    int ones;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    if (pen) begin
      bits[9]  = podd ? ((ones % 2) == 0) : ((ones % 2) == 1);
      bits[10] = 1'b1;
      len = 11;
    end else begin
      bits[9]  = 1'b1;
      bits[10] = 1'b1;
      len = 10;
    end
    par_en_i = pen; par_odd_i = podd;
    data_i = d; valid_i = 1'b1;
    @(posedge clk); #1;
    chk({req, " R2 idle low after accept"}, idle_o, 1'b0);
    if (hold_valid) data_i = ~d; else valid_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      do_ticks(8);
      chk({req, " R3 R4 tx bit"}, tx_pin_o, bits[k]);
      chk({req, " R9 rx feed"}, rx_feed_o, sys_lpbk_i ? bits[k] : rx_pin_i);
      if (hold_valid) chk("R7 R2 ready low in frame", ready_o, 1'b0);
      do_ticks(8);
    end
    chk({req, " R5 idle after stop"}, idle_o, 1'b1);
    chk({req, " R5 tx rests high"}, tx_pin_o, 1'b1);
    valid_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 tx after reset", tx_pin_o, 1'b1);
    chk("R1 idle after reset", idle_o, 1'b1);
    chk("R1 ready with enable low", ready_o, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    tx_en_i = 1'b1;
    #1;
    chk("R1 ready follows enable", ready_o, 1'b1);

    // table of frames
    for (int v = 0; v < 6; v++) begin
      send(VECS[v][9:2], VECS[v][1], VECS[v][0], 1'b0, "table");
    end

    // R7: valid held high through a frame
    send(8'h5A, 1'b1, 1'b1, 1'b1, "R7 held valid");
    repeat (3) @(posedge clk); #1;
    chk("R7 no second frame", idle_o, 1'b1);

    // R6: disabled engine takes nothing
    tx_en_i = 1'b0; data_i = 8'h11; valid_i = 1'b1;
    #1;
    chk("R6 ready low when disabled", ready_o, 1'b0);
    repeat (4) @(posedge clk); #1;
    chk("R6 no accept when disabled", idle_o, 1'b1);
    chk("R6 tx high when disabled", tx_pin_o, 1'b1);
    valid_i = 1'b0; tx_en_i = 1'b1;

    // R6: abort mid-frame
    data_i = 8'h00; par_en_i = 1'b0; valid_i = 1'b1;
    @(posedge clk); #1;
    valid_i = 1'b0;
    do_ticks(24);
    chk("R6 in data bit 0", tx_pin_o, 1'b0);
    tx_en_i = 1'b0;
    @(posedge clk); #1;
    chk("R6 abort idle", idle_o, 1'b1);
    chk("R6 abort tx high", tx_pin_o, 1'b1);
    tx_en_i = 1'b1;

    // R9: system loopback during a frame, pin held opposite
    sys_lpbk_i = 1'b1; rx_pin_i = 1'b1;
    send(8'hC3, 1'b1, 1'b0, 1'b0, "R9 sys loopback");
    sys_lpbk_i = 1'b0;
    rx_pin_i = 1'b0; #1;
    chk("R9 feed from pin", rx_feed_o, 1'b0);

    // R8: line loopback
    line_lpbk_i = 1'b1;
    rx_pin_i = 1'b0; #1;
    chk("R8 line loopback low", tx_pin_o, 1'b0);
    rx_pin_i = 1'b1; #1;
    chk("R8 line loopback high", tx_pin_o, 1'b1);

    // R10: override beats line loopback
    ovrd_en_i = 1'b1; ovrd_val_i = 1'b0; #1;
    chk("R10 override over line", tx_pin_o, 1'b0);
    line_lpbk_i = 1'b0; ovrd_val_i = 1'b1;

    // R10: override beats serializer start bit
    data_i = 8'h00; par_en_i = 1'b1; valid_i = 1'b1;
    @(posedge clk); #1;
    valid_i = 1'b0;
    do_ticks(8);
    chk("R10 override over serializer", tx_pin_o, 1'b1);
    ovrd_en_i = 1'b0; #1;
    chk("R11 serializer visible", tx_pin_o, 1'b0);
    do_ticks(8 + 16 * 10);
    chk("R11 back to rest", tx_pin_o, 1'b1);
    chk("R5 idle after forced frame", idle_o, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule